// File: doc/BRIEF.md
# Memory Abort Classifier and Exception Router

This unit sits between the memory-system fault reporters and the exception entry logic of a processor core. When an abort is signalled, it chooses one reporter if several raise a fault together. It decides whether the fault is internal or external, and whether it is precise or imprecise. It also picks a fault-status code class and the processor mode that will service the fault.

On the cycle after an abort strobe, it presents a registered one-cycle verdict to the exception sequencer. The verdict comes with a pulse meaning "take the exception now" and with the interrupt mask updates to apply on entry. A routing configuration bit can send external faults to a secure monitor mode instead of the ordinary abort mode. The bit is captured together with the strobe.

Top module: `abort_router`

## Requirements
- R1: After reset, and in every cycle without a verdict, all outputs are 0: take_exc, is_ext, is_precise, mask_irq, mask_fiq, fsr_sel = 0 (none) and tgt_mode = 0 (none).
- R2: A fault from the translation-lookaside checks (src_vec bit 1) is internal and precise, reports fsr_sel = 2, and always targets abort mode (tgt_mode = 1), whatever the routing bit.
- R3: A fault from a translation table walk (src_vec bit 2) is external and precise and reports fsr_sel = 3.
- R4: An external bus fault (src_vec bit 3) is precise and reports fsr_sel = 4 when any of these holds: so_mem = 1, acc_kind = 2 (swap load half), or acc_kind = 3 (load to PC or status register).
- R5: An external bus fault with so_mem = 0 and acc_kind = 0 (load) or 1 (store) is imprecise and reports fsr_sel = 5.
- R6: A watchpoint fault (src_vec bit 0) is internal and precise, reports fsr_sel = 1, and targets abort mode even when the routing bit is 1.
- R7: With ext_to_mon = 1, every external fault (table walk or bus) targets monitor mode (tgt_mode = 2). With ext_to_mon = 0 it targets abort mode (tgt_mode = 1).
- R8: mask_irq is 1 with every verdict. mask_fiq is 1 only when tgt_mode is monitor.
- R9: A strobe with at least one source bit set yields exactly one cycle of take_exc with the verdict, in the cycle after the strobe.
- R10: When several source bits are set together, the fixed priority is watchpoint, then lookaside check, then table walk, then external bus.
- R11: The routing bit is taken in the strobe cycle. Changing it in the following cycle does not alter the verdict already captured.
- R12: A strobe with no source bit set, or source bits without the strobe, produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abt_valid | input | 1 | Abort event strobe |
| src_vec | input | 4 | Fault reporters: bit0 watchpoint, bit1 lookaside check, bit2 table walk, bit3 external bus |
| acc_kind | input | 2 | Access: 0 load, 1 store, 2 swap load, 3 load to PC/status |
| so_mem | input | 1 | Access targets strongly-ordered memory |
| ext_to_mon | input | 1 | Route external faults to monitor mode |
| take_exc | output | 1 | One-cycle exception entry pulse |
| is_ext | output | 1 | Fault is external |
| is_precise | output | 1 | Fault is precise |
| fsr_sel | output | 3 | Fault-status class code |
| tgt_mode | output | 2 | Target mode: 0 none, 1 abort, 2 monitor |
| mask_irq | output | 1 | Mask IRQ on entry |
| mask_fiq | output | 1 | Mask FIQ on entry |

## Verification
A wrong choice in the priority select appears one cycle after the strobe as the wrong fsr_sel class. It is caught by feeding combined source vectors whose winners differ. A faulty precision or routing decision shows up as a mismatch of is_precise, fsr_sel, tgt_mode or mask_fiq on that same verdict cycle. A stuck or lengthened output register shows up in the cycle after the pulse as a nonzero output while no strobe is present.

// File: rtl/abort_pkg.sv
package abort_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_WP   = 0;
  localparam int SRC_TLB  = 1;
  localparam int SRC_WALK = 2;
  localparam int SRC_BUS  = 3;
  localparam int ACC_W    = 2;
  localparam int FS_W     = 3;
  localparam int MODE_W   = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_SWAP_LD = 2'd2, ACC_PC_LD = 2'd3
  } acc_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_NONE = 2'd0, MODE_ABT = 2'd1, MODE_MON = 2'd2
  } mode_e;

  typedef enum logic [FS_W-1:0] {
    FS_NONE = 3'd0, FS_WATCH = 3'd1, FS_TLB = 3'd2, FS_WALK = 3'd3,
    FS_EXT_PREC = 3'd4, FS_EXT_IMPR = 3'd5
  } fs_e;

  typedef struct packed {
    logic  ext;
    logic  precise;
    fs_e   fs;
    mode_e mode;
    logic  mirq;
    logic  mfiq;
  } verdict_t;

  localparam verdict_t VERDICT_IDLE = '{ext: 1'b0, precise: 1'b0, fs: FS_NONE,
                                         mode: MODE_NONE, mirq: 1'b0, mfiq: 1'b0};

  // Bus fault precision: ordered memory, swap load half, or PC/status load.
  function automatic logic bus_precise(input logic so, input acc_e acc);
    return so || (acc == ACC_SWAP_LD) || (acc == ACC_PC_LD);
  endfunction

  function automatic mode_e pick_mode(input logic ext, input logic to_mon);
    return (ext && to_mon) ? MODE_MON : MODE_ABT;
  endfunction
endpackage

// File: rtl/abort_arbiter.sv
module abort_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/abort_classifier.sv
module abort_classifier
  import abort_pkg::*;
(
  input  logic [NSRC-1:0] grant,
  input  acc_e            acc,
  input  logic            so_mem,
  input  logic            to_mon,
  output verdict_t        verdict
);
  always_comb begin
    verdict = VERDICT_IDLE;
    if (grant[SRC_WP]) begin
      verdict.ext     = 1'b0;
      verdict.precise = 1'b1;
      verdict.fs      = FS_WATCH;
    end else if (grant[SRC_TLB]) begin
      verdict.ext     = 1'b0;
      verdict.precise = 1'b1;
      verdict.fs      = FS_TLB;
    end else if (grant[SRC_WALK]) begin
      verdict.ext     = 1'b1;
      verdict.precise = 1'b1;
      verdict.fs      = FS_WALK;
    end else if (grant[SRC_BUS]) begin
      verdict.ext     = 1'b1;
      verdict.precise = bus_precise(so_mem, acc);
      verdict.fs      = verdict.precise ? FS_EXT_PREC : FS_EXT_IMPR;
    end
    if (|grant) begin
      verdict.mode = pick_mode(verdict.ext, to_mon);
      verdict.mirq = 1'b1;
      verdict.mfiq = (verdict.mode == MODE_MON);
    end
  end
endmodule

// File: rtl/abort_outreg.sv
module abort_outreg
  import abort_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  verdict_t next_v,
  output logic     pulse,
  output verdict_t cur_v
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      cur_v <= VERDICT_IDLE;
    end else if (load) begin
      pulse <= 1'b1;
      cur_v <= next_v;
    end else begin
      pulse <= 1'b0;
      cur_v <= VERDICT_IDLE;
    end
  end
endmodule

// File: rtl/abort_router.sv
module abort_router
  import abort_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abt_valid,
  input  logic [NSRC-1:0]      src_vec,
  input  logic [ACC_W-1:0]     acc_kind,
  input  logic                 so_mem,
  input  logic                 ext_to_mon,
  output logic                 take_exc,
  output logic                 is_ext,
  output logic                 is_precise,
  output logic [FS_W-1:0]      fsr_sel,
  output logic [MODE_W-1:0]    tgt_mode,
  output logic                 mask_irq,
  output logic                 mask_fiq
);
  logic [NSRC-1:0] grant_w;
  logic            any_w;
  logic            hit_w;
  verdict_t        next_w;
  verdict_t        cur_w;

  abort_arbiter #(.N(NSRC)) u_arb (
    .req   (src_vec),
    .grant (grant_w),
    .any   (any_w)
  );

  abort_classifier u_cls (
    .grant   (grant_w),
    .acc     (acc_e'(acc_kind)),
    .so_mem  (so_mem),
    .to_mon  (ext_to_mon),
    .verdict (next_w)
  );

  assign hit_w = abt_valid & any_w;

  abort_outreg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hit_w),
    .next_v (next_w),
    .pulse  (take_exc),
    .cur_v  (cur_w)
  );

  assign is_ext     = cur_w.ext;
  assign is_precise = cur_w.precise;
  assign fsr_sel    = cur_w.fs;
  assign tgt_mode   = cur_w.mode;
  assign mask_irq   = cur_w.mirq;
  assign mask_fiq   = cur_w.mfiq;
endmodule

// File: rtl/abort_router_chk.sv
module abort_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abt_valid,
  input logic [3:0] src_vec,
  input logic [3:0] grant,
  input logic       take_exc,
  input logic       is_ext,
  input logic       is_precise,
  input logic [2:0] fsr_sel,
  input logic [1:0] tgt_mode,
  input logic       mask_irq,
  input logic       mask_fiq
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> (fsr_sel == 3'd0 && tgt_mode == 2'd0 && !mask_irq && !mask_fiq
                   && !is_ext && !is_precise));

  p_internal_precise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && !is_ext) |-> (is_precise && tgt_mode == 2'd1));

  p_impr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && is_ext && !is_precise) |-> fsr_sel == 3'd5);

  p_watch_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_valid && src_vec[0]) |=> fsr_sel == 3'd1);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_mon_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && tgt_mode == 2'd2) |-> is_ext);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> mask_irq);

  p_fiq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_fiq |-> (take_exc && tgt_mode == 2'd2));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_valid && |src_vec) |=> take_exc);

  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(abt_valid && |src_vec) |=> !take_exc);
endmodule

bind abort_router abort_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abt_valid  (abt_valid),
  .src_vec    (src_vec),
  .grant      (grant_w),
  .take_exc   (take_exc),
  .is_ext     (is_ext),
  .is_precise (is_precise),
  .fsr_sel    (fsr_sel),
  .tgt_mode   (tgt_mode),
  .mask_irq   (mask_irq),
  .mask_fiq   (mask_fiq)
);

// File: tb/abort_router_bench.sv
module abort_router_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abt_valid = 1'b0;
  logic [3:0] src_vec = 4'd0;
  logic [1:0] acc_kind = 2'd0;
  logic       so_mem = 1'b0;
  logic       ext_to_mon = 1'b0;
  logic       take_exc, is_ext, is_precise, mask_irq, mask_fiq;
  logic [2:0] fsr_sel;
  logic [1:0] tgt_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  abort_router u_abort_router (
    .clk(clk), .rst_n(rst_n), .abt_valid(abt_valid), .src_vec(src_vec),
    .acc_kind(acc_kind), .so_mem(so_mem), .ext_to_mon(ext_to_mon),
    .take_exc(take_exc), .is_ext(is_ext), .is_precise(is_precise),
    .fsr_sel(fsr_sel), .tgt_mode(tgt_mode), .mask_irq(mask_irq), .mask_fiq(mask_fiq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Compares all outputs against expected values: {take, ext, prec, fs, mode, irq, fiq}
  task automatic chk_all(input string tag, input int tk, input int ex, input int pr,
                         input int fs, input int md, input int iq, input int fq);
    chk({tag, " take"}, take_exc, tk);
    chk({tag, " ext"}, is_ext, ex);
    chk({tag, " precise"}, is_precise, pr);
    chk({tag, " fsr"}, fsr_sel, fs);
    chk({tag, " mode"}, tgt_mode, md);
    chk({tag, " irq"}, mask_irq, iq);
    chk({tag, " fiq"}, mask_fiq, fq);
  endtask

  // Drive one strobe on a falling edge; the verdict is registered at the next
  // rising edge and sampled on the following falling edge.
  task automatic strobe(input logic [3:0] s, input logic [1:0] a, input logic so, input logic rt);
    @(negedge clk);
    abt_valid = 1'b1; src_vec = s; acc_kind = a; so_mem = so; ext_to_mon = rt;
    @(negedge clk);
    abt_valid = 1'b0; src_vec = 4'd0;
  endtask

  task automatic t_reset;
    chk_all("R1 reset", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_tlb;
    strobe(4'b0010, 2'd0, 1'b0, 1'b0);
    chk_all("R2 tlb", 1, 0, 1, 2, 1, 1, 0);
    strobe(4'b0010, 2'd1, 1'b0, 1'b1);
    chk_all("R2 tlb routed", 1, 0, 1, 2, 1, 1, 0);
  endtask

  task automatic t_walk;
    strobe(4'b0100, 2'd0, 1'b0, 1'b0);
    chk_all("R3 walk", 1, 1, 1, 3, 1, 1, 0);
  endtask

  task automatic t_bus_precise;
    strobe(4'b1000, 2'd1, 1'b1, 1'b0);
    chk_all("R4 ordered store", 1, 1, 1, 4, 1, 1, 0);
    strobe(4'b1000, 2'd2, 1'b0, 1'b0);
    chk_all("R4 swap load", 1, 1, 1, 4, 1, 1, 0);
    strobe(4'b1000, 2'd3, 1'b0, 1'b0);
    chk_all("R4 pc load", 1, 1, 1, 4, 1, 1, 0);
  endtask

  task automatic t_bus_imprecise;
    strobe(4'b1000, 2'd0, 1'b0, 1'b0);
    chk_all("R5 plain load", 1, 1, 0, 5, 1, 1, 0);
    strobe(4'b1000, 2'd1, 1'b0, 1'b0);
    chk_all("R5 plain store", 1, 1, 0, 5, 1, 1, 0);
  endtask

  task automatic t_watch;
    strobe(4'b0001, 2'd0, 1'b0, 1'b1);
    chk_all("R6 watchpoint routed", 1, 0, 1, 1, 1, 1, 0);
  endtask

  task automatic t_monitor;
    strobe(4'b0100, 2'd0, 1'b0, 1'b1);
    chk_all("R7 R8 walk to monitor", 1, 1, 1, 3, 2, 1, 1);
    strobe(4'b1000, 2'd0, 1'b0, 1'b1);
    chk_all("R7 R8 bus to monitor", 1, 1, 0, 5, 2, 1, 1);
  endtask

  task automatic t_pulse;
    strobe(4'b1000, 2'd3, 1'b0, 1'b0);
    chk_all("R9 pulse cycle", 1, 1, 1, 4, 1, 1, 0);
    @(negedge clk);
    chk_all("R9 after pulse", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    strobe(4'b1111, 2'd0, 1'b0, 1'b1);
    chk_all("R10 all sources", 1, 0, 1, 1, 1, 1, 0);
    strobe(4'b1110, 2'd0, 1'b0, 1'b1);
    chk_all("R10 tlb over walk", 1, 0, 1, 2, 1, 1, 0);
    strobe(4'b1100, 2'd0, 1'b0, 1'b1);
    chk_all("R10 walk over bus", 1, 1, 1, 3, 2, 1, 1);
  endtask

  task automatic t_route_capture;
    @(negedge clk);
    abt_valid = 1'b1; src_vec = 4'b1000; acc_kind = 2'd0; so_mem = 1'b0; ext_to_mon = 1'b1;
    @(negedge clk);
    abt_valid = 1'b0; src_vec = 4'd0; ext_to_mon = 1'b0;
    #1;
    chk_all("R11 captured route", 1, 1, 0, 5, 2, 1, 1);
    strobe(4'b1000, 2'd0, 1'b0, 1'b0);
    chk_all("R11 new route", 1, 1, 0, 5, 1, 1, 0);
  endtask

  task automatic t_no_source;
    strobe(4'b0000, 2'd3, 1'b1, 1'b1);
    chk_all("R12 strobe no source", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    src_vec = 4'b1111;
    @(negedge clk);
    src_vec = 4'b0000;
    chk_all("R12 source no strobe", 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_tlb;
    t_walk;
    t_bus_precise;
    t_bus_imprecise;
    t_watch;
    t_monitor;
    t_pulse;
    t_priority;
    t_route_capture;
    t_no_source;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule